// File: doc/BRIEF.md
# Cell Header Check and Frame Marker Monitor

This block watches a byte-wide stream of received ATM cells. Each cell begins with a byte that carries a start-of-cell strobe. The block takes the first four bytes of the cell as the header and computes a CRC-8 over them. It then compares the fifth byte, the header check byte, against that CRC. The cell stream leaves the block one cycle later. A verdict comes with the check byte: good, errored, or frame marker.

The frame marker is the first of 56 containers. It is recognised because its check byte equals the CRC with a fixed coset added. Frame alignment therefore comes from the header check itself, and no extra sync word is needed. From the marker on, the block numbers the containers of the frame.

An option input selects what happens to errored cells. With the option set, the block flags them for discard. With it clear, they pass on unflagged. Errored cells are counted in a saturating counter, which a clear pulse resets.

Top module: `hec_frame_monitor`

## Requirements
- R1: After a byte with `in_soc`=1, the block takes four accepted header bytes and computes CRC-8 over them, using generator 0x07, initial value 0, most significant bit first. The next accepted byte is the check byte. In the cycle that byte appears on the output, `hec_chk` is 1. `hec_err` is also 1 when the byte equals neither the CRC nor the CRC XOR `COSET`.
- R2: `out_valid`, `out_soc` and `out_byte` repeat `in_valid`, `in_valid & in_soc` and `in_byte`, one cycle later.
- R3: A check byte equal to the CRC XOR `COSET` (0x55) is a valid cell and not an error. It raises `frame_sof` for one cycle, together with `hec_chk`.
- R4: On a frame marker, `cont_idx` becomes 0. While the block is aligned, every later checked cell, good or errored, moves `cont_idx` up by one, and after `FRAME_LEN-1` it returns to 0. `cont_idx` changes in the cycle of the `hec_chk` pulse.
- R5: After reset and until the first marker, `frame_locked` is 0 and `cont_idx` stays 0. Cells are still checked and counted during this time. The first marker sets `frame_locked` to 1.
- R6: When `drop_en` is 1 at the check byte of an errored cell, `out_discard` is 1 for every output byte of that cell, from the check byte up to the next start of cell. With `drop_en` at 0, `out_discard` stays 0. Header bytes are never flagged.
- R7: Each errored cell raises `err_count` by one, in the cycle of its `hec_chk` pulse. The count holds at 2^`CNT_W`-1 instead of wrapping.
- R8: `cnt_clr` sets `err_count` to 0 on the next cycle. If an errored check byte arrives in the same cycle as `cnt_clr`, the count becomes 1.
- R9: During reset all outputs are 0.
- R10: Bytes with `in_valid`=0 have no effect. A new `in_soc` that arrives before the check byte abandons the partial cell without a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drop_en | input | 1 | Flag errored cells for discard |
| cnt_clr | input | 1 | Clear pulse for the errored-cell count |
| in_valid | input | 1 | Input byte valid |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| in_byte | input | 8 | Input data byte |
| out_valid | output | 1 | Output byte valid |
| out_soc | output | 1 | Output byte is the first byte of a cell |
| out_byte | output | 8 | Output data byte |
| out_discard | output | 1 | Output byte belongs to a cell to be dropped |
| hec_chk | output | 1 | Verdict pulse with the check byte |
| hec_err | output | 1 | Check byte was wrong |
| frame_sof | output | 1 | Check byte marked the start of a frame |
| frame_locked | output | 1 | A frame marker has been seen |
| cont_idx | output | $clog2(FRAME_LEN) | Container index within the frame |
| err_count | output | CNT_W | Saturating errored-cell count |

## Verification
The bench builds the block with `CNT_W`=3, so that the errored-cell count saturates at 7 after a handful of bad cells. The coincidence of a clear pulse with an error is also reachable at that width. `FRAME_LEN` keeps its default of 56, and 60 aligned cells in a row carry the container index through its wrap. Short payloads and random idle gaps keep each cell to a few cycles. Idle cycles also land between header bytes.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

    localparam int HDR_BYTES = 4;
    localparam int POS_W     = $clog2(HDR_BYTES + 2);

    // One byte of CRC-8, generator x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             in_cell;
        logic             hold;
        logic             ov;
        logic             osoc;
        logic [7:0]       obyte;
        logic             odisc;
        logic             chk;
        logic             err;
        logic             sof;
    } mon_state_t;

endpackage

// File: rtl/hfm_crc_acc.sv
module hfm_crc_acc
    import hfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       adv,
    input  logic [7:0] data,
    output logic [7:0] crc
);
    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (start) begin
            crc_d = crc8_step(8'h00, data);
        end else if (adv) begin
            crc_d = crc8_step(crc_q, data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R1: the running CRC moves only on header bytes
    p_crc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !adv) |=> $stable(crc_q));

endmodule

// File: rtl/hfm_frame_track.sv
module hfm_frame_track #(
    parameter int FRAME_LEN = 56
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cell_done,
    input  logic                         marker,
    output logic [$clog2(FRAME_LEN)-1:0] idx,
    output logic                         locked
);
    localparam int               IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             locked;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cell_done) begin
            if (marker) begin
                s_d.idx    = '0;
                s_d.locked = 1'b1;
            end else if (s_q.locked) begin
                s_d.idx = (s_q.idx == LAST) ? '0 : s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx    = s_q.idx;
    assign locked = s_q.locked;

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= LAST);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_done && !marker && s_q.locked && s_q.idx == LAST) |=> (s_q.idx == '0));

    p_unlocked_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.locked |-> (s_q.idx == '0));

endmodule

// File: rtl/hfm_err_count.sv
module hfm_err_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q;
        if (inc && cnt_d != MAX) begin
            cnt_d = cnt_d + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX && !clr) |=> (cnt_q == MAX));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt_q == '0));

endmodule

// File: rtl/hec_frame_monitor.sv
module hec_frame_monitor
    import hfm_pkg::*;
#(
    parameter int         FRAME_LEN = 56,
    parameter int         CNT_W     = 16,
    parameter logic [7:0] COSET     = 8'h55
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         drop_en,
    input  logic                         cnt_clr,
    input  logic                         in_valid,
    input  logic                         in_soc,
    input  logic [7:0]                   in_byte,
    output logic                         out_valid,
    output logic                         out_soc,
    output logic [7:0]                   out_byte,
    output logic                         out_discard,
    output logic                         hec_chk,
    output logic                         hec_err,
    output logic                         frame_sof,
    output logic                         frame_locked,
    output logic [$clog2(FRAME_LEN)-1:0] cont_idx,
    output logic [CNT_W-1:0]             err_count
);
    localparam logic [POS_W-1:0] HDR_POS = POS_W'(HDR_BYTES);

    mon_state_t s_d, s_q;
    logic [7:0] crc_q;
    logic       crc_adv, is_hec, hec_mark, hec_bad;

    assign crc_adv  = in_valid && !in_soc && s_q.in_cell && (s_q.pos < HDR_POS);
    assign is_hec   = in_valid && !in_soc && s_q.in_cell && (s_q.pos == HDR_POS);
    assign hec_mark = (in_byte == (crc_q ^ COSET));
    assign hec_bad  = (in_byte != crc_q) && !hec_mark;

    always_comb begin
        s_d       = s_q;
        s_d.ov    = in_valid;
        s_d.osoc  = in_valid && in_soc;
        s_d.obyte = in_byte;
        s_d.odisc = 1'b0;
        s_d.chk   = 1'b0;
        s_d.err   = 1'b0;
        s_d.sof   = 1'b0;
        if (in_valid) begin
            if (in_soc) begin
                s_d.pos     = POS_W'(1);
                s_d.in_cell = 1'b1;
                s_d.hold    = 1'b0;
            end else if (s_q.in_cell) begin
                if (s_q.pos < HDR_POS) begin
                    s_d.pos = s_q.pos + 1'b1;
                end else if (is_hec) begin
                    s_d.pos   = HDR_POS + 1'b1;
                    s_d.chk   = 1'b1;
                    s_d.err   = hec_bad;
                    s_d.sof   = hec_mark;
                    s_d.hold  = hec_bad && drop_en;
                    s_d.odisc = hec_bad && drop_en;
                end else begin
                    s_d.odisc = s_q.hold;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    hfm_crc_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (in_valid && in_soc),
        .adv   (crc_adv),
        .data  (in_byte),
        .crc   (crc_q)
    );

    hfm_frame_track #(.FRAME_LEN(FRAME_LEN)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_done (is_hec),
        .marker    (hec_mark),
        .idx       (cont_idx),
        .locked    (frame_locked)
    );

    hfm_err_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (is_hec && hec_bad),
        .clr   (cnt_clr),
        .count (err_count)
    );

    assign out_valid   = s_q.ov;
    assign out_soc     = s_q.osoc;
    assign out_byte    = s_q.obyte;
    assign out_discard = s_q.odisc;
    assign hec_chk     = s_q.chk;
    assign hec_err     = s_q.err;
    assign frame_sof   = s_q.sof;

    p_sof_idx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sof |-> (cont_idx == '0 && frame_locked));

    p_sof_not_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sof |-> (hec_chk && !hec_err));

    p_clean_no_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hec_chk && !hec_err) |-> !out_discard);

    p_err_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hec_err |-> (err_count != '0));

    p_discard_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_discard |-> (out_valid && !out_soc));

endmodule

// File: tb/tb_hec_frame_monitor.sv
`timescale 1ns/1ps
module tb_hec_frame_monitor;

    localparam int FRAME_LEN = 56;
    localparam int CNT_W     = 3;
    localparam int CNT_MAX   = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drop_en = 1'b0, cnt_clr = 1'b0;
    logic       in_valid = 1'b0, in_soc = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_soc, out_discard, hec_chk, hec_err, frame_sof, frame_locked;
    logic [7:0] out_byte;
    logic [$clog2(FRAME_LEN)-1:0] cont_idx;
    logic [CNT_W-1:0] err_count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hec_frame_monitor #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .COSET(8'h55)) dut (
        .clk(clk), .rst_n(rst_n), .drop_en(drop_en), .cnt_clr(cnt_clr),
        .in_valid(in_valid), .in_soc(in_soc), .in_byte(in_byte),
        .out_valid(out_valid), .out_soc(out_soc), .out_byte(out_byte),
        .out_discard(out_discard), .hec_chk(hec_chk), .hec_err(hec_err),
        .frame_sof(frame_sof), .frame_locked(frame_locked),
        .cont_idx(cont_idx), .err_count(err_count)
    );

    // polynomial long division of header * x^8 by 0x107
    function automatic logic [7:0] ref_crc(input logic [31:0] h);
        logic [39:0] r;
        r = {h, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        end
        return r[7:0];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] hdr[$];
    bit  seen = 0, judged = 0, hold = 0, m_lock = 0;
    int  m_idx = 0, m_cnt = 0;
    bit  e_valid = 0, e_soc = 0, e_chk = 0, e_err = 0, e_sof = 0, e_disc = 0;
    logic [7:0] e_byte = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            hdr.delete(); seen = 0; judged = 0; hold = 0; m_lock = 0; m_idx = 0; m_cnt = 0;
            e_valid = 0; e_soc = 0; e_chk = 0; e_err = 0; e_sof = 0; e_disc = 0; e_byte = 0;
        end else begin
            e_valid = in_valid; e_soc = in_valid && in_soc; e_byte = in_byte;
            e_chk = 0; e_err = 0; e_sof = 0; e_disc = 0;
            if (cnt_clr) m_cnt = 0;
            if (in_valid) begin
                if (in_soc) begin
                    hdr.delete(); hdr.push_back(in_byte);
                    seen = 1; judged = 0; hold = 0;
                end else if (seen && !judged) begin
                    if (hdr.size() < 4) hdr.push_back(in_byte);
                    else begin
                        logic [7:0] c;
                        c = ref_crc({hdr[0], hdr[1], hdr[2], hdr[3]});
                        judged = 1;
                        e_chk = 1;
                        e_sof = (in_byte == (c ^ 8'h55));
                        e_err = (in_byte != c) && !e_sof;
                        if (e_err && m_cnt < CNT_MAX) m_cnt++;
                        hold = e_err && drop_en;
                        e_disc = hold;
                        if (e_sof) begin m_idx = 0; m_lock = 1; end
                        else if (m_lock) m_idx = (m_idx + 1) % FRAME_LEN;
                    end
                end else if (seen) begin
                    e_disc = hold;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check("R2 out_valid", out_valid, e_valid);
            check("R2 out_soc", out_soc, e_soc);
            if (e_valid) check("R2 out_byte", out_byte, e_byte);
            check("R1 hec_chk", hec_chk, e_chk);
            check("R1 hec_err", hec_err, e_err);
            check("R3 frame_sof", frame_sof, e_sof);
            check("R6 out_discard", out_discard, e_disc);
            check("R5 frame_locked", frame_locked, m_lock);
            check("R4 cont_idx", cont_idx, m_idx);
            check("R7 err_count", err_count, m_cnt);
        end
    end

    task automatic drive(input logic [7:0] b, input bit soc, input bit clr);
        if ($urandom_range(0, 4) == 0) begin
            @(negedge clk); in_valid = 0; in_soc = 0; cnt_clr = 0;   // R10 idle gap
        end
        @(negedge clk);
        in_valid = 1; in_soc = soc; in_byte = b; cnt_clr = clr;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); in_valid = 0; in_soc = 0; cnt_clr = 0; in_byte = 8'hEE;
        end
    endtask

    // kind: 0 good, 1 errored, 2 frame marker
    task automatic send_cell(input logic [31:0] h, input int kind, input bit clr_hec);
        logic [7:0] c;
        c = ref_crc(h);
        if (kind == 1) c = c ^ 8'hA3;
        if (kind == 2) c = c ^ 8'h55;
        drive(h[31:24], 1, 0);
        drive(h[23:16], 0, 0);
        drive(h[15:8], 0, 0);
        drive(h[7:0], 0, 0);
        drive(c, 0, clr_hec);
        for (int k = 0; k < 3; k++) drive(8'(k * 37 + 5), 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 out_valid in reset", out_valid, 0);
        check("R9 hec_chk in reset", hec_chk, 0);
        check("R9 frame_locked in reset", frame_locked, 0);
        check("R9 err_count in reset", err_count, 0);
        rst_n = 1;
        idle(2);

        // unaligned: checked and counted, no lock (R5)
        send_cell(32'h0012_3456, 0, 0);
        send_cell(32'hDEAD_BEEF, 1, 0);
        send_cell(32'h0000_0000, 0, 0);
        send_cell(32'hFFFF_FFFF, 1, 0);
        idle(2);
        check("R5 still unlocked", frame_locked, 0);
        check("R5 errors counted before lock", err_count, 2);

        // truncated cell, abandoned by a new start (R10)
        drive(8'h11, 1, 0); drive(8'h22, 0, 0);
        send_cell(32'h1234_5678, 0, 0);
        idle(2);
        check("R10 partial cell no verdict", err_count, 2);

        // marker then long run across the wrap (R3, R4)
        send_cell(32'h0A0B_0C0D, 2, 0);
        idle(1);
        check("R3 locked after marker", frame_locked, 1);
        for (int n = 1; n <= 60; n++) send_cell(32'h0100_0000 + n * 7919, (n == 30) ? 1 : 0, 0);
        idle(2);
        check("R4 index after wrap", cont_idx, 60 % FRAME_LEN);

        // discard mode (R6)
        drop_en = 1;
        send_cell(32'hCAFE_0001, 1, 0);
        send_cell(32'hCAFE_0002, 0, 0);
        send_cell(32'hCAFE_0003, 1, 0);
        idle(2);
        drop_en = 0;

        // saturation (R7)
        for (int n = 0; n < 8; n++) send_cell(32'h5A5A_0000 + n, 1, 0);
        idle(2);
        check("R7 saturated count", err_count, CNT_MAX);

        // clear alone, then clear with an error (R8)
        @(negedge clk); cnt_clr = 1;
        idle(1);
        check("R8 cleared", err_count, 0);
        send_cell(32'hBEEF_0001, 1, 0);
        send_cell(32'hBEEF_0002, 1, 1);
        idle(2);
        check("R8 clear with error gives one", err_count, 1);

        // marker mid-frame restarts index (R4)
        send_cell(32'h7777_7777, 0, 0);
        send_cell(32'h3141_5926, 2, 0);
        idle(2);
        check("R4 index back to zero", cont_idx, 0);

        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule